// File: doc/BRIEF.md
# Programmable-Latency Read Data Output Pipeline

This block sits between the column access logic of a synchronous DRAM core and its data pins. In every cycle the array side may present one read beat. The block delays that beat by a read latency of two or three clocks and then drives it onto the data bus. Three controls can hold a beat off the bus. The data mask, taken two clocks earlier, releases the bus for a single slot. A terminate strobe, standing in for a precharge or a burst stop, drops the rest of a burst. A synchronous reset empties the whole path.

A new burst can begin in any cycle, so back-to-back read commands leave no gap in the output stream. The write direction has no pipeline. In the same cycle, the mask decides whether the incoming write beat reaches the array. The latency select may change only while no read beat is in flight.

Top module: `cl_read_pipe`

## Requirements
- R1: With lat_sel low (latency 2), a beat that passes the gate in cycle c is driven on dq_out, with dq_oe high, in cycle c+2.
- R2: With lat_sel high (latency 3), a beat that passes the gate in cycle c is driven on dq_out, with dq_oe high, in cycle c+3. When the select is switched while the pipeline is empty, the next beat follows the new latency.
- R3: When dqm is high in cycle d, dq_oe is low in cycle d+2, whatever the beat in that slot. A dqm pulse has no effect on the slots before or after that one.
- R4: Whenever dq_oe is low, dq_out is all zeros, which stands for the high-impedance bus. dq_oe is high only in a cycle that carries a valid beat that is not masked.
- R5: A high term in cycle p drops the beat of cycle p, and also every later beat that has rd_start low, so the bus stays released from cycle p+latency onward. Beats accepted before cycle p still come out. If term and rd_start are high in the same cycle, term wins.
- R6: A beat with rd_vld and rd_start high and term low starts a new burst. It passes even after a termination. Starts in consecutive cycles produce output in consecutive cycles with no gap.
- R7: wr_en is rd-independent and equals wr_vld AND NOT dqm in the same cycle. wr_data_o equals wr_data when wr_en is high and is zero otherwise.
- R8: A high rst at a clock edge clears every pipeline stage, the mask history and the termination state. dq_oe is low in the following cycle, and a beat that follows with rd_start low is passed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| lat_sel | input | 1 | Read latency select: 0 gives 2 clocks, 1 gives 3 clocks |
| rd_vld | input | 1 | Read beat present from the array side this cycle |
| rd_start | input | 1 | This beat is the first beat of a new burst |
| rd_data | input | 4 | Read beat data |
| dqm | input | 1 | Data mask: masks the read slot two cycles later and the write beat in this cycle |
| term | input | 1 | Burst truncation strobe (precharge or burst stop) |
| wr_vld | input | 1 | Write beat present on the pins this cycle |
| wr_data | input | 4 | Write beat data |
| dq_out | output | 4 | Read data bus, zero while released |
| dq_oe | output | 1 | Bus drive enable |
| wr_en | output | 1 | Write beat accepted after masking |
| wr_data_o | output | 4 | Write data toward the array |

## Verification
The bench builds the block with its defaults: a three-stage delay line, a two-stage mask history and a 4-bit beat. The run first covers the latency-2 tap, then switches to the latency-3 tap on an empty pipe, and then goes back. This reaches the mask's fixed two-clock distance both where it is shorter than the read latency and where it equals it. The 4-bit beat is wide enough that random data show whether a beat lands in the wrong slot. Directed runs of back-to-back starts, terminations during a burst and a reset in the middle of a burst sit among the random cycles.

// File: rtl/clrp_pkg.sv
package clrp_pkg;

    localparam int unsigned DQ_W = 4;

    typedef enum logic {
        LAT2 = 1'b0,
        LAT3 = 1'b1
    } lat_e;

    typedef struct packed {
        logic            vld;
        logic [DQ_W-1:0] data;
    } beat_t;

    function automatic int unsigned lat_depth(lat_e l);
        return (l == LAT3) ? 3 : 2;
    endfunction

endpackage

// File: rtl/clrp_burst_gate.sv
module clrp_burst_gate
    import clrp_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            rd_vld,
    input  logic            rd_start,
    input  logic [DQ_W-1:0] rd_data,
    input  logic            term,
    output beat_t           beat_o
);
    logic killed;

    always_ff @(posedge clk) begin
        if (rst)
            killed <= 1'b0;
        else if (term)
            killed <= 1'b1;
        else if (rd_vld && rd_start)
            killed <= 1'b0;
    end

    always_comb begin
        beat_o.vld  = rd_vld && !term && (rd_start || !killed);
        beat_o.data = rd_data;
    end
endmodule

// File: rtl/clrp_delay_line.sv
module clrp_delay_line
    import clrp_pkg::*;
#(
    parameter int unsigned MAX_LAT = 3
) (
    input  logic  clk,
    input  logic  rst,
    input  lat_e  lat,
    input  beat_t din,
    output beat_t dout
);
    beat_t stg [MAX_LAT];

    for (genvar i = 0; i < MAX_LAT; i++) begin : g_stage
        if (i == 0) begin : g_head
            always_ff @(posedge clk) begin
                if (rst) stg[0] <= '0;
                else     stg[0] <= din;
            end
        end else begin : g_body
            always_ff @(posedge clk) begin
                if (rst) stg[i] <= '0;
                else     stg[i] <= stg[i-1];
            end
        end
    end

    always_comb dout = stg[lat_depth(lat) - 1];
endmodule

// File: rtl/clrp_mask_delay.sv
module clrp_mask_delay #(
    parameter int unsigned DEPTH = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic din,
    output logic dout
);
    logic [DEPTH-1:0] hist;

    always_ff @(posedge clk) begin
        if (rst) hist <= '0;
        else     hist <= {hist[DEPTH-2:0], din};
    end

    assign dout = hist[DEPTH-1];
endmodule

// File: rtl/clrp_wr_mask.sv
module clrp_wr_mask
    import clrp_pkg::*;
(
    input  logic            wr_vld,
    input  logic            dqm,
    input  logic [DQ_W-1:0] wr_data,
    output logic            wr_en,
    output logic [DQ_W-1:0] wr_data_o
);
    always_comb begin
        wr_en     = wr_vld && !dqm;
        wr_data_o = wr_en ? wr_data : '0;
    end
endmodule

// File: rtl/cl_read_pipe.sv
module cl_read_pipe
    import clrp_pkg::*;
#(
    parameter int unsigned MAX_LAT  = 3,
    parameter int unsigned MASK_LAT = 2
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            lat_sel,
    input  logic            rd_vld,
    input  logic            rd_start,
    input  logic [DQ_W-1:0] rd_data,
    input  logic            dqm,
    input  logic            term,
    input  logic            wr_vld,
    input  logic [DQ_W-1:0] wr_data,
    output logic [DQ_W-1:0] dq_out,
    output logic            dq_oe,
    output logic            wr_en,
    output logic [DQ_W-1:0] wr_data_o
);
    beat_t gated;
    beat_t tap;
    logic  mask_now;
    lat_e  lat;

    assign lat = lat_e'(lat_sel);

    clrp_burst_gate gate_i (
        .clk(clk), .rst(rst), .rd_vld(rd_vld), .rd_start(rd_start),
        .rd_data(rd_data), .term(term), .beat_o(gated)
    );

    clrp_delay_line #(.MAX_LAT(MAX_LAT)) line_i (
        .clk(clk), .rst(rst), .lat(lat), .din(gated), .dout(tap)
    );

    clrp_mask_delay #(.DEPTH(MASK_LAT)) mask_i (
        .clk(clk), .rst(rst), .din(dqm), .dout(mask_now)
    );

    clrp_wr_mask wmask_i (
        .wr_vld(wr_vld), .dqm(dqm), .wr_data(wr_data),
        .wr_en(wr_en), .wr_data_o(wr_data_o)
    );

    always_comb begin
        dq_oe  = tap.vld && !mask_now;
        dq_out = dq_oe ? tap.data : '0;
    end
endmodule

// File: rtl/clrp_checker.sv
module clrp_checker
    import clrp_pkg::*;
(
    input logic            clk,
    input logic            rst,
    input logic            lat_sel,
    input logic            rd_vld,
    input logic            rd_start,
    input logic [DQ_W-1:0] rd_data,
    input logic            dqm,
    input logic            term,
    input logic            wr_vld,
    input logic [DQ_W-1:0] wr_data,
    input logic [DQ_W-1:0] dq_out,
    input logic            dq_oe,
    input logic            wr_en,
    input logic [DQ_W-1:0] wr_data_o
);
    AST_LAT2_SLOT: assert property (@(posedge clk) disable iff (rst)
        (dq_oe && !lat_sel) |-> ($past(rd_vld, 2) && dq_out == $past(rd_data, 2))); // R1
    AST_LAT3_SLOT: assert property (@(posedge clk) disable iff (rst)
        (dq_oe && lat_sel) |-> ($past(rd_vld, 3) && dq_out == $past(rd_data, 3))); // R2
    AST_READ_MASK: assert property (@(posedge clk) disable iff (rst)
        $past(dqm, 2) |-> !dq_oe); // R3
    AST_BUS_RELEASE: assert property (@(posedge clk) disable iff (rst)
        !dq_oe |-> (dq_out == '0)); // R4
    AST_TERM_LAT2: assert property (@(posedge clk) disable iff (rst)
        ($past(term, 2) && !lat_sel) |-> !dq_oe); // R5
    AST_TERM_LAT3: assert property (@(posedge clk) disable iff (rst)
        ($past(term, 3) && lat_sel) |-> !dq_oe); // R5
    AST_WR_MASKED: assert property (@(posedge clk) disable iff (rst)
        dqm |-> !wr_en); // R7
    AST_WR_PASS: assert property (@(posedge clk) disable iff (rst)
        wr_en |-> (wr_data_o == wr_data && wr_vld)); // R7
endmodule

bind cl_read_pipe clrp_checker chk_i (.*);

// File: tb/cl_read_pipe_tb.sv
module cl_read_pipe_tb_top;
    import clrp_pkg::*;

    localparam int CLK_PERIOD = 10;
    localparam int NCYC       = 4000;
    localparam int WDOG_CYC   = 20000;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic            lat_sel = 1'b0;
    logic            rd_vld = 1'b0, rd_start = 1'b0, dqm = 1'b0, term = 1'b0, wr_vld = 1'b0;
    logic [DQ_W-1:0] rd_data = '0, wr_data = '0;
    logic [DQ_W-1:0] dq_out, wr_data_o;
    logic            dq_oe, wr_en;

    always #(CLK_PERIOD/2) clk = ~clk;

    cl_read_pipe dut_i (
        .clk(clk), .rst(rst), .lat_sel(lat_sel), .rd_vld(rd_vld), .rd_start(rd_start),
        .rd_data(rd_data), .dqm(dqm), .term(term), .wr_vld(wr_vld), .wr_data(wr_data),
        .dq_out(dq_out), .dq_oe(dq_oe), .wr_en(wr_en), .wr_data_o(wr_data_o)
    );

    int n_chk = 0, n_fail = 0, cyc = 0;
    bit done = 0;
    logic            h_pass [NCYC];
    logic            h_vld  [NCYC];
    logic            h_dqm  [NCYC];
    logic            h_rst  [NCYC];
    logic [DQ_W-1:0] h_data [NCYC];
    logic            kill_m = 1'b0;

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s cycle %0d actual %0h expected %0h", tag, cyc, act, exp);
        end
    endtask

    function automatic bit rst_in(int a, int b);
        for (int i = a; i <= b; i++) if (i >= 0 && h_rst[i]) return 1;
        return 0;
    endfunction

    // One cycle: apply inputs at the falling edge, then check against the model.
    task automatic step(input logic r, input logic v, input logic s, input logic t,
                        input logic m, input logic [DQ_W-1:0] d);
        int lat, c;
        logic e_oe;
        logic [DQ_W-1:0] e_dq;
        string tag;
        @(negedge clk);
        rst = r; rd_vld = v; rd_start = s; term = t; dqm = m; rd_data = d;
        wr_vld  = 1'($urandom_range(0, 1));
        wr_data = DQ_W'($urandom);
        h_rst[cyc] = r; h_vld[cyc] = v; h_dqm[cyc] = m; h_data[cyc] = d;
        h_pass[cyc] = v && !t && (s || !kill_m);
        if (r) kill_m = 1'b0;
        else if (t) kill_m = 1'b1;
        else if (v && s) kill_m = 1'b0;
        #1;
        lat = lat_sel ? 3 : 2;
        c = cyc - lat;
        e_oe = 1'b0;
        e_dq = '0;
        if (c >= 0 && h_pass[c] && !rst_in(c, cyc - 1) && !h_dqm[cyc - 2]) begin
            e_oe = 1'b1;
            e_dq = h_data[c];
        end
        if (rst_in(cyc - lat, cyc - 1))        tag = "R8";
        else if (cyc >= 2 && h_dqm[cyc - 2])  tag = "R3";
        else if (c >= 0 && h_vld[c] && !h_pass[c]) tag = "R5";
        else tag = lat_sel ? "R2" : "R1";
        chk(tag, {3'b0, dq_oe, dq_out}, {3'b0, e_oe, e_dq});
        if (!dq_oe) chk("R4", {4'b0, dq_out}, 8'h0);
        chk("R7", {3'b0, wr_en, wr_data_o},
            {3'b0, wr_vld && !dqm, (wr_vld && !dqm) ? wr_data : 4'h0});
        cyc++;
    endtask

    task automatic idle(input int k);
        for (int i = 0; i < k; i++) step(0, 0, 0, 0, 0, '0);
    endtask

    task automatic rand_run(input int k);
        for (int i = 0; i < k; i++)
            step(0, ($urandom_range(0, 9) < 7), ($urandom_range(0, 9) < 2),
                 ($urandom_range(0, 19) == 0), ($urandom_range(0, 9) < 2), DQ_W'($urandom));
    endtask

    task automatic directed();
        // R6: starts in consecutive cycles, no gap
        for (int i = 0; i < 4; i++) step(0, 1, 1, 0, 0, DQ_W'(i + 3));
        // R5: terminate in the middle of a burst, then non-start beats dropped
        step(0, 1, 1, 0, 0, 4'hA);
        step(0, 1, 0, 0, 0, 4'hB);
        step(0, 1, 0, 1, 0, 4'hC);
        step(0, 1, 0, 0, 0, 4'hD);
        step(0, 1, 1, 1, 0, 4'hE);   // term wins over a start
        step(0, 1, 1, 0, 0, 4'h5);   // R6 restart after termination
        step(0, 1, 0, 0, 1, 4'h6);   // R3 single dqm pulse
        step(0, 1, 0, 0, 0, 4'h7);
        step(0, 1, 0, 0, 0, 4'h8);
        idle(4);
    endtask

    initial begin
        void'($urandom(32'd20250611));
        for (int i = 0; i < NCYC; i++) begin
            h_pass[i] = 0; h_vld[i] = 0; h_dqm[i] = 0; h_rst[i] = 1; h_data[i] = '0;
        end
        step(1, 0, 0, 0, 0, '0);
        step(1, 0, 0, 0, 0, '0);
        chk("R8", {7'b0, dq_oe}, 8'h0);
        idle(2);
        directed();
        rand_run(600);
        idle(4);
        @(negedge clk) lat_sel = 1'b1;       // switch on an empty pipe
        directed();
        rand_run(600);
        // R8: reset in the middle of a burst, then a non-start beat passes
        step(0, 1, 1, 0, 0, 4'h9);
        step(0, 1, 0, 1, 0, 4'h1);
        step(1, 1, 0, 0, 0, 4'h2);
        step(0, 1, 0, 0, 0, 4'h3);
        idle(4);
        @(negedge clk) lat_sel = 1'b0;
        directed();
        rand_run(600);
        idle(4);
        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (WDOG_CYC) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog expired at cycle %0d", cyc);
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule